// File: doc/BRIEF.md
# Ringing-to-Talk Transition Sequencer

This block steps a line-card access switch controller from the power-ringing state to the talk state. It drives the controller's three state-select lines, its input-latch enable and its active-low shutdown override. A single start pulse launches one transition, and a one-cycle done pulse reports that the talk state has been reached.

Three orderings are offered, and one is picked at start time. In the direct mode, the select lines go straight from the ringing pattern to the talk pattern. In the staged mode, the select lines first command all switches open, hold that for half a ringing period, and then select talk. In the override mode, the shutdown line is pulled low for half a ringing period and the select lines are moved from ringing to talk underneath it. Releasing the override then lets the talk selection take effect. The half-period hold is computed from clock and ringing frequency parameters.

Top module: `rtt_ring_talk_seq`

## Requirements
- R1: After reset and until the first accepted start, `ctl_o` = 3'b100 (ringing), `shutdown_no` = 1 and `done_o` = 0. The `ctl_o` bit order is {bit2 ringing select, bit1 inner test select, bit0 outer test select}.
- R2: The hold length is H = CLK_HZ / (2*RING_HZ) clock cycles, using integer division, and H must be at least 2.
- R3: In the direct mode, the cycle after the accepting edge shows `ctl_o` = 3'b000 (talk) with `done_o` = 1.
- R4: In the staged mode, `ctl_o` = 3'b101 (all open) with `shutdown_no` = 1 for exactly H cycles after the accepting edge, followed by 3'b000 with `done_o` = 1.
- R5: In the override mode, `shutdown_no` = 0 for exactly H cycles after the accepting edge. During those cycles `ctl_o` shows 3'b100 for the first H - H/2 cycles and 3'b000 for the rest. After that, `shutdown_no` returns to 1 in the same cycle that `done_o` = 1.
- R6: The `mode_i` encoding is 0 = direct, 1 = staged, 2 = override and 3 = direct. The mode is captured on the accepting edge, and later changes to `mode_i` have no effect on a running sequence.
- R7: A start received while a hold is in progress is ignored, and the running sequence finishes on its original schedule.
- R8: `done_o` is high for one cycle only, in the first talk cycle. Afterwards `ctl_o` stays at 3'b000 with `done_o` = 0 until the next start, and a start is accepted in that state.
- R9: `latch_o` is 0 at all times, so that changes on the select lines pass straight through.
- R10: `ctl_o` never shows 3'b101 while `shutdown_no` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a transition (sampled on rising edge) |
| mode_i | input | 2 | Transition ordering select |
| ctl_o | output | 3 | State-select lines to the switch controller |
| latch_o | output | 1 | Input-latch enable (0 = transparent) |
| shutdown_no | output | 1 | Shutdown override, active low |
| done_o | output | 1 | One-cycle pulse on reaching talk |

## Verification
The bench builds two copies of the block. One uses CLK_HZ = 2000 and RING_HZ = 20, which gives an even hold of 50 cycles. The other uses CLK_HZ = 1400, which gives an odd hold of 35 cycles, so the rounding of the override mode's midpoint switch is exercised. These short holds make it possible to check every cycle of every ordering against an arithmetic model. The sweep also covers all four mode codes, with and without a stray start and mode change during the hold.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  typedef enum logic [1:0] {
    MODE_DIRECT  = 2'd0,
    MODE_STAGED  = 2'd1,
    MODE_OVRD    = 2'd2,
    MODE_DIRECT2 = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ST_RING = 2'd0,
    ST_HOLD = 2'd1,
    ST_TALK = 2'd2
  } state_e;

  localparam logic [2:0] PAT_RING = 3'b100;
  localparam logic [2:0] PAT_OPEN = 3'b101;
  localparam logic [2:0] PAT_TALK = 3'b000;

  function automatic int unsigned hold_cycles(int unsigned clk_hz, int unsigned ring_hz);
    return clk_hz / (2 * ring_hz);
  endfunction
endpackage

// File: rtl/rtt_hold_timer.sv
module rtt_hold_timer #(
  parameter int unsigned HOLD  = 50,
  parameter int unsigned CNT_W = $clog2(HOLD)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= CNT_W'(HOLD - 1);
    else if (en_i && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  // R7: a running hold is never reloaded
  a_r7_steady_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/rtt_seq_fsm.sv
module rtt_seq_fsm
  import rtt_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic [1:0] mode_i,
  input  logic   tmr_zero_i,
  output state_e state_o,
  output mode_e  mode_o,
  output logic   load_o,
  output logic   en_o,
  output logic   done_o
);
  state_e state_q;
  mode_e  mode_q;
  logic   done_q;
  logic   needs_hold;

  assign needs_hold = (mode_i == MODE_STAGED) || (mode_i == MODE_OVRD);
  assign load_o     = start_i && (state_q != ST_HOLD);
  assign en_o       = (state_q == ST_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RING;
      mode_q  <= MODE_DIRECT;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q == ST_HOLD) begin
        if (tmr_zero_i) begin
          state_q <= ST_TALK;
          done_q  <= 1'b1;
        end
      end else if (start_i) begin
        mode_q <= mode_e'(mode_i);
        if (needs_hold) begin
          state_q <= ST_HOLD;
        end else begin
          state_q <= ST_TALK;
          done_q  <= 1'b1;
        end
      end
    end
  end

  assign state_o = state_q;
  assign mode_o  = mode_q;
  assign done_o  = done_q;

  // R6: captured mode is frozen during a hold
  a_r6_mode_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && $past(state_q) == ST_HOLD) |-> $stable(mode_q));
endmodule

// File: rtl/rtt_out_map.sv
module rtt_out_map
  import rtt_pkg::*;
#(
  parameter int unsigned HOLD  = 50,
  parameter int unsigned CNT_W = $clog2(HOLD)
) (
  input  state_e           state_i,
  input  mode_e            mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [2:0]       ctl_o,
  output logic             shutdown_no
);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(HOLD / 2);

  always_comb begin
    ctl_o       = PAT_RING;
    shutdown_no = 1'b1;
    case (state_i)
      ST_TALK: ctl_o = PAT_TALK;
      ST_HOLD: begin
        if (mode_i == MODE_OVRD) begin
          shutdown_no = 1'b0;
          ctl_o       = (cnt_i >= HALF) ? PAT_RING : PAT_TALK;
        end else begin
          ctl_o = PAT_OPEN;
        end
      end
      default: ctl_o = PAT_RING;
    endcase
  end
endmodule

// File: rtl/rtt_ring_talk_seq.sv
module rtt_ring_talk_seq
  import rtt_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 125_000_000,
  parameter int unsigned RING_HZ = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] mode_i,
  output logic [2:0] ctl_o,
  output logic       latch_o,
  output logic       shutdown_no,
  output logic       done_o
);
  localparam int unsigned HOLD  = hold_cycles(CLK_HZ, RING_HZ);
  localparam int unsigned CNT_W = (HOLD > 2) ? $clog2(HOLD) : 1;

  state_e           state;
  mode_e            mode_q;
  logic             load, en, zero;
  logic [CNT_W-1:0] cnt;

  rtt_seq_fsm u_fsm (
    .clk_i, .rst_ni, .start_i, .mode_i,
    .tmr_zero_i(zero), .state_o(state), .mode_o(mode_q),
    .load_o(load), .en_o(en), .done_o
  );

  rtt_hold_timer #(.HOLD(HOLD), .CNT_W(CNT_W)) u_tmr (
    .clk_i, .rst_ni, .load_i(load), .en_i(en), .cnt_o(cnt), .zero_o(zero)
  );

  rtt_out_map #(.HOLD(HOLD), .CNT_W(CNT_W)) u_map (
    .state_i(state), .mode_i(mode_q), .cnt_i(cnt), .ctl_o, .shutdown_no
  );

  assign latch_o = 1'b0;

  // R2: hold must be long enough for a split override window
  initial a_r2_hold_min: assert (HOLD >= 2);

  a_r8_done_in_talk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ctl_o == PAT_TALK);
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o || $past(start_i)));
  a_r10_no_open_overridden: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shutdown_no |-> ctl_o != PAT_OPEN);
  a_r5_release_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shutdown_no) |-> done_o);
endmodule

// File: tb/rtt_ring_talk_seq_tb.sv
module rtt_ring_talk_seq_tb;
  localparam int HA = 50;
  localparam int HB = 35;

  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] mode = 0;
  logic [2:0] ctl_a, ctl_b;
  logic lat_a, lat_b, sd_a, sd_b, dn_a, dn_b;
  int errors = 0, checks = 0;
  bit  finished = 0;

  always #4 clk = ~clk;

  rtt_ring_talk_seq #(.CLK_HZ(2000), .RING_HZ(20)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .ctl_o(ctl_a), .latch_o(lat_a), .shutdown_no(sd_a), .done_o(dn_a));

  rtt_ring_talk_seq #(.CLK_HZ(1400), .RING_HZ(20)) u_dut_odd (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .ctl_o(ctl_b), .latch_o(lat_b), .shutdown_no(sd_b), .done_o(dn_b));

  task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {ctl,sd,done} act=%b exp=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_latch(string req);
    checks++;
    if (lat_a !== 1'b0 || lat_b !== 1'b0) begin
      errors++;
      $display("FAIL %s: latch act=%b%b exp=00", req, lat_a, lat_b);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // expected {ctl, sd, done} at cycle j after accepting edge
  function automatic logic [4:0] model(int m, int h, int j);
    int mm = (m == 3) ? 0 : m;
    if (mm == 0) return {3'b000, 1'b1, 1'(j == 1)};
    if (j <= h) begin
      if (mm == 1) return {3'b101, 1'b1, 1'b0};
      return {((j <= h - h / 2) ? 3'b100 : 3'b000), 1'b0, 1'b0};
    end
    return {3'b000, 1'b1, 1'(j == h + 1)};
  endfunction

  function automatic string tag(int m, int poke);
    if (poke != 0) return "R7";
    case (m)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic run_seq(int m, int poke);
    start = 1;
    mode  = 2'(m);
    for (int j = 1; j <= HA + 3; j++) begin
      tick();
      chk(tag(m, poke), {ctl_a, sd_a, dn_a}, model(m, HA, j));
      chk(tag(m, poke), {ctl_b, sd_b, dn_b}, model(m, HB, j));
      chk_latch("R9");
      start = (poke != 0 && j == poke);
      if (poke != 0 && j == poke) mode = 2'((m + 1) % 4);  // R6 mid-run change
    end
    start = 0;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R8", {ctl_a, sd_a, dn_a}, 5'b00010);
      chk("R8", {ctl_b, sd_b, dn_b}, 5'b00010);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick();
    tick();
    rst_n = 1;
    for (int k = 0; k < 4; k++) begin
      tick();
      chk("R1", {ctl_a, sd_a, dn_a}, 5'b10010);
      chk("R1", {ctl_b, sd_b, dn_b}, 5'b10010);
      chk_latch("R9");
    end
    for (int m = 0; m < 4; m++) begin
      run_seq(m, 0);
      if (m == 1 || m == 2) run_seq(m, 3);
    end
    // R8: back-to-back start right on the done cycle
    start = 1; mode = 2'd0;
    tick();
    chk("R8", {ctl_a, sd_a, dn_a}, 5'b00011);
    tick();
    chk("R8", {ctl_a, sd_a, dn_a}, 5'b00011);
    start = 0;
    tick();
    chk("R8", {ctl_a, sd_a, dn_a}, 5'b00010);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule